// File: doc/BRIEF.md
# Event Duration and Count Recorder

This block watches one event input and keeps two running totals: the time the input has spent active, in quarter-second units, and the number of completed events. The raw input passes through a synchronizer and a tick-based glitch filter. A level change is accepted only after it has held for a set number of ticks. While the filtered event is active, a phase counter first waits out a start delay and then paces a steady step interval, and each due step advances the time counter.

A free-running 1 ms tick enable replaces a real time base, so every interval is expressed in ticks and can be shrunk for simulation. The time counter is compared with a programmable alarm value. An exact match with a nonzero alarm sets a flag that stays set. A one-clock load strobe marks each accepted start and a one-clock commit strobe marks each accepted end, so that external storage can fetch and save the counters. A clear request zeroes the counters and the flag only when the grant input permits it in the same cycle.

Top module: `evt_time_log`

## Requirements
- R1: A change of the synchronized input level is accepted only after it differs from the filtered level on GLITCH_TICKS consecutive tick cycles. A shorter pulse changes neither `evt_active`, the counters nor the strobes, and `evt_active` changes only at the clock edge of a tick cycle.
- R2: After an accepted start, `elapsed` advances by one on the START_TICKS-th tick and then on every STEP_TICKS-th tick while the event stays accepted. A raw high lasting H ticks (H at least GLITCH_TICKS) adds 0 when H < START_TICKS and 1 + (H - START_TICKS) / STEP_TICKS otherwise.
- R3: `events` advances by one at each accepted end of an event and never at a start. An event too short for any time step is still counted.
- R4: `elapsed` holds at its all-ones value instead of wrapping.
- R5: `events` holds at its all-ones value instead of wrapping.
- R6: `alarm_flag` sets in the clock cycle after `elapsed` equals a nonzero `alarm_val`. An `alarm_val` of zero never sets it.
- R7: Once set, `alarm_flag` stays set until a granted clear.
- R8: `load_strobe` pulses for one clock after an accepted start and `commit_strobe` for one clock after an accepted end. The two never pulse together.
- R9: `clr_req` high together with `clr_grant` high zeroes `elapsed`, `events` and `alarm_flag` at the next edge, taking priority over any increment. `clr_req` without `clr_grant` has no effect.
- R10: After reset all outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | One-cycle time-base enable, nominally every 1 ms |
| evt_in | input | 1 | Raw, asynchronous event level (high = active) |
| clr_req | input | 1 | Counter clear request |
| clr_grant | input | 1 | Permission for the clear request |
| alarm_val | input | TIME_W | Alarm compare value; zero disables the compare |
| elapsed | output | TIME_W | Accumulated active time in steps |
| events | output | CNT_W | Completed event count |
| alarm_flag | output | 1 | Sticky alarm match flag |
| load_strobe | output | 1 | One-clock pulse at an accepted start |
| commit_strobe | output | 1 | One-clock pulse at an accepted end |
| evt_active | output | 1 | Filtered event level |

## Verification
The bench builds the block with TIME_W = 8, CNT_W = 4, GLITCH_TICKS = 3, START_TICKS = 4 and STEP_TICKS = 8. With these values both saturation points can be reached in a few thousand ticks. The short intervals also let directed pulses land just below and just at the glitch, start and step boundaries. Random runs of high and low levels, random alarm values close to the count, and granted and ungranted clears are compared tick by tick against a behavioural model.

// File: rtl/evt_time_log.sv
module evt_time_log #(
  parameter int TIME_W       = 32,
  parameter int CNT_W        = 17,
  parameter int SYNC_STAGES  = 2,
  parameter int GLITCH_TICKS = 35,
  parameter int START_TICKS  = 125,
  parameter int STEP_TICKS   = 250
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              evt_in,
  input  logic              clr_req,
  input  logic              clr_grant,
  input  logic [TIME_W-1:0] alarm_val,
  output logic [TIME_W-1:0] elapsed,
  output logic [CNT_W-1:0]  events,
  output logic              alarm_flag,
  output logic              load_strobe,
  output logic              commit_strobe,
  output logic              evt_active
);

  localparam int PH_MAX = (START_TICKS > STEP_TICKS) ? START_TICKS : STEP_TICKS;
  localparam int PH_W   = $clog2(PH_MAX + 1);
  localparam int GL_W   = $clog2(GLITCH_TICKS + 1);
  localparam logic [TIME_W-1:0] TIME_TOP = {TIME_W{1'b1}};
  localparam logic [CNT_W-1:0]  CNT_TOP  = {CNT_W{1'b1}};

  logic [SYNC_STAGES-1:0] sync_q;
  logic                   lvl;
  logic                   filt;
  logic [GL_W-1:0]        gl_cnt;
  logic                   flip, rise_now, fall_now;
  logic [PH_W-1:0]        ph;
  logic                   started;
  logic                   step_due;
  logic                   do_clr;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[SYNC_STAGES-2:0], evt_in};

  assign lvl      = sync_q[SYNC_STAGES-1];
  assign flip     = tick && (lvl != filt) && (gl_cnt == GL_W'(GLITCH_TICKS - 1));
  assign rise_now = flip && lvl;
  assign fall_now = flip && !lvl;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      filt   <= 1'b0;
      gl_cnt <= '0;
    end else if (tick) begin
      if (lvl == filt)  gl_cnt <= '0;
      else if (flip) begin
        filt   <= lvl;
        gl_cnt <= '0;
      end else          gl_cnt <= gl_cnt + 1'b1;
    end

  assign step_due = tick && filt &&
                    (started ? (ph == PH_W'(STEP_TICKS - 1)) : (ph == PH_W'(START_TICKS - 1)));

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      ph      <= '0;
      started <= 1'b0;
    end else if (rise_now) begin
      ph      <= '0;
      started <= 1'b0;
    end else if (tick && filt) begin
      if (step_due) begin
        ph      <= '0;
        started <= 1'b1;
      end else ph <= ph + 1'b1;
    end

  assign do_clr = clr_req && clr_grant;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)                               elapsed <= '0;
    else if (do_clr)                          elapsed <= '0;
    else if (step_due && elapsed != TIME_TOP) elapsed <= elapsed + 1'b1;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)                             events <= '0;
    else if (do_clr)                        events <= '0;
    else if (fall_now && events != CNT_TOP) events <= events + 1'b1;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)                                      alarm_flag <= 1'b0;
    else if (do_clr)                                 alarm_flag <= 1'b0;
    else if (alarm_val != '0 && elapsed == alarm_val) alarm_flag <= 1'b1;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      load_strobe   <= 1'b0;
      commit_strobe <= 1'b0;
    end else begin
      load_strobe   <= rise_now;
      commit_strobe <= fall_now;
    end

  assign evt_active = filt;

  AST_FILTER_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> $stable(evt_active)); // R1
  AST_TIME_STEP_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    !do_clr |=> (elapsed == $past(elapsed) || elapsed == $past(elapsed) + TIME_W'(1))); // R2
  AST_EVENTS_AT_END: assert property (@(posedge clk) disable iff (!rst_n)
    (!do_clr && !fall_now) |=> $stable(events)); // R3
  AST_TIME_NO_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (elapsed == TIME_TOP && !do_clr) |=> elapsed == TIME_TOP); // R4
  AST_EVENTS_NO_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (events == CNT_TOP && !do_clr) |=> events == CNT_TOP); // R5
  AST_ALARM_ZERO_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    (alarm_val == '0 && !alarm_flag) |=> !alarm_flag); // R6
  AST_ALARM_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (alarm_flag && !do_clr) |=> alarm_flag); // R7
  AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(load_strobe && commit_strobe)); // R8
  AST_CLEAR_GRANTED: assert property (@(posedge clk) disable iff (!rst_n)
    do_clr |=> (elapsed == '0 && events == '0 && !alarm_flag)); // R9

endmodule

// File: tb/sim_evt_time_log.sv
module sim_evt_time_log;
  localparam int TW = 8, CW = 4, G = 3, S = 4, ST = 8;

  logic clk = 1'b0, rst_n = 1'b0, tick = 1'b0, evt_in = 1'b0;
  logic clr_req = 1'b0, clr_grant = 1'b0;
  logic [TW-1:0] alarm_val = '0;
  logic [TW-1:0] elapsed;
  logic [CW-1:0] events;
  logic alarm_flag, load_strobe, commit_strobe, evt_active;

  int checks = 0, errors = 0;
  bit done = 0;
  int m_f, m_g, m_ph, m_st, m_el, m_ev, m_fl, m_rise, m_fall;
  int cur_alarm = 0;

  evt_time_log #(.TIME_W(TW), .CNT_W(CW), .SYNC_STAGES(2), .GLITCH_TICKS(G),
                 .START_TICKS(S), .STEP_TICKS(ST)) u0 (
    .clk(clk), .rst_n(rst_n), .tick(tick), .evt_in(evt_in), .clr_req(clr_req),
    .clr_grant(clr_grant), .alarm_val(alarm_val), .elapsed(elapsed), .events(events),
    .alarm_flag(alarm_flag), .load_strobe(load_strobe), .commit_strobe(commit_strobe),
    .evt_active(evt_active));

  always #10 clk = ~clk;

  task automatic check(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic int amatch(int el, int av);
    return (av != 0 && el == av) ? 1 : 0;
  endfunction

  task automatic model_tick(int lv, int clr);
    int old_f;
    old_f = m_f; m_rise = 0; m_fall = 0;
    if (lv != m_f) begin
      m_g++;
      if (m_g == G) begin
        m_f = lv; m_g = 0; m_rise = lv; m_fall = 1 - lv;
      end
    end else m_g = 0;
    if (old_f == 1) begin
      if ((m_st == 0 && m_ph + 1 == S) || (m_st == 1 && m_ph + 1 == ST)) begin
        if (m_el != (1 << TW) - 1) m_el++;
        m_ph = 0; m_st = 1;
      end else m_ph++;
    end
    if (m_rise == 1) begin m_ph = 0; m_st = 0; end
    if (m_fall == 1 && m_ev != (1 << CW) - 1) m_ev++;
    if (clr == 1) begin m_el = 0; m_ev = 0; m_fl = 0; end
  endtask

  task automatic step(int lv, int cr, int cg);
    @(negedge clk);
    evt_in = lv[0]; alarm_val = TW'(cur_alarm);
    m_fl = m_fl | amatch(m_el, cur_alarm);
    repeat (2) @(negedge clk);
    tick = 1'b1; clr_req = cr[0]; clr_grant = cg[0];
    @(negedge clk);
    tick = 1'b0; clr_req = 1'b0; clr_grant = 1'b0;
    model_tick(lv, cr & cg);
    check("R8 load_strobe", int'(load_strobe), m_rise);
    check("R8 commit_strobe", int'(commit_strobe), m_fall);
    check("R1 evt_active", int'(evt_active), m_f);
    @(negedge clk);
    m_fl = m_fl | amatch(m_el, cur_alarm);
    check("R2 elapsed", int'(elapsed), m_el);
    check("R3 events", int'(events), m_ev);
    check("R6 alarm_flag", int'(alarm_flag), m_fl);
  endtask

  task automatic pulse(int h);
    repeat (h) step(1, 0, 0);
    repeat (G + 1) step(0, 0, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    int e0, t0, seed;
    seed = $urandom(32'd1234);
    m_f = 0; m_g = 0; m_ph = 0; m_st = 0; m_el = 0; m_ev = 0; m_fl = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R10 elapsed", int'(elapsed), 0);
    check("R10 events", int'(events), 0);
    check("R10 alarm_flag", int'(alarm_flag), 0);
    check("R10 strobes", int'(load_strobe | commit_strobe | evt_active), 0);

    e0 = events; t0 = elapsed;
    pulse(G - 1);
    check("R1 glitch events", int'(events), e0);
    check("R1 glitch elapsed", int'(elapsed), t0);

    pulse(S - 1);
    check("R3 zero-length counted", int'(events), e0 + 1);
    check("R3 zero-length time", int'(elapsed), t0);

    t0 = elapsed; pulse(S);
    check("R2 first step", int'(elapsed), t0 + 1);
    t0 = elapsed; pulse(S + ST - 1);
    check("R2 just below second", int'(elapsed), t0 + 1);
    t0 = elapsed; pulse(S + ST);
    check("R2 second step", int'(elapsed), t0 + 2);
    check("R6 zero alarm idle", int'(alarm_flag), 0);

    cur_alarm = int'(elapsed) + 2;
    pulse(S + ST);
    check("R6 alarm set", int'(alarm_flag), 1);
    pulse(S + 2 * ST);
    check("R7 alarm sticky", int'(alarm_flag), 1);

    e0 = events; t0 = elapsed;
    step(0, 1, 0);
    check("R9 ungranted events", int'(events), e0);
    check("R9 ungranted elapsed", int'(elapsed), t0);
    check("R9 ungranted flag", int'(alarm_flag), 1);
    step(0, 1, 1);
    check("R9 granted clear", int'(elapsed) + int'(events) + int'(alarm_flag), 0);

    cur_alarm = 0;
    repeat (18) pulse(G);
    check("R5 events saturate", int'(events), (1 << CW) - 1);

    pulse(S + 256 * ST);
    check("R4 elapsed saturate", int'(elapsed), (1 << TW) - 1);
    step(0, 1, 1);

    for (int i = 0; i < 300; i++) begin
      int lv, len, cr, cg;
      lv = int'($urandom_range(0, 1));
      len = int'($urandom_range(1, 14));
      if ($urandom_range(0, 7) == 0) cur_alarm = int'($urandom_range(0, 12));
      for (int k = 0; k < len; k++) begin
        cr = ($urandom_range(0, 40) == 0) ? 1 : 0;
        cg = int'($urandom_range(0, 1));
        step(lv, cr, cg);
      end
    end

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule